// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that runs from a slow free-running clock of about 32 kHz. Software sets it up through one 8-bit control register on the system clock. Five bits of that register hold an arming key. Three bits pick how long the watchdog waits before it acts. There is no way to stop the watchdog. The key accepts exactly two legal patterns, and both of them leave the counter running. Any other key pattern makes the block ask the chip's reset controller for a reset a short, fixed time later. This protects against a stray write that corrupts the register.

Software restarts the count with a clear strobe that is one system clock wide. If the count reaches the selected limit during normal operation, the block raises a chip reset request. If the limit is reached while the chip is powered down, the block instead gives a one-cycle wake-up pulse and leaves the control register unchanged. A separate status register holds a sticky flag that records a watchdog-caused reset. The flag survives the reset it caused. Only power-on reset or a software write of 0 clears it.

Register values and the clear strobe cross into the slow domain through toggle signals. Each toggle passes a two-flop synchroniser, and the slow domain then captures the register contents.

Top module: `kwdt_top`

## Requirements
- R1: The control register (address 0) is 8 bits, fully readable and writable. Bits 7:3 are the key field and bits 2:0 are the timeout select. A write is visible on a read in the next system clock cycle.
- R2: Any reset (por_n or rst_n low) loads the control register with 8'h53, which is key 01010 and select 011.
- R3: Keys 01010 and 10101 keep the watchdog counting with no reset request, including when software switches between the two. Any other key raises chip_rst_req exactly 2 wdt_clk cycles after the slow domain captures it.
- R4: Select code s gives a timeout of 2^E wdt_clk periods after the last clear. E = 8, 10, 12, 14 for s = 0..3 and E = 15, 16, 17, 18 for s = 4..7. A timeout outside power-down raises chip_rst_req.
- R5: The timeout fires when the count is greater than or equal to the limit. If software lowers the select while the count is already past the new limit, the timeout fires within a few wdt_clk cycles.
- R6: A wdt_clr pulse one system clock wide restarts the count from zero. The slow domain acts on it within 4 wdt_clk cycles.
- R7: The status register (address 1) returns the watchdog-reset flag in bit 0 and 0 in bits 7:1. The flag sets whenever chip_rst_req rises, for a bad key or a timeout. It is unaffected by rst_n, cleared by por_n or by writing 0 to bit 0, and writing 1 to it has no effect.
- R8: A timeout while pwr_down is high produces a wake_pulse of exactly one wdt_clk cycle. It does not raise chip_rst_req or change the control register, and counting restarts.
- R9: Once chip_rst_req is high it stays high until rst_n is asserted.
- R10: A control write reaches the slow domain through a two-flop synchronised update toggle and takes effect within 4 wdt_clk cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register port |
| clk_wdt | input | 1 | Slow watchdog source clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| wdt_clr | input | 1 | Watchdog clear strobe, system clock |
| pwr_down | input | 1 | High while the chip is powered down |
| chip_rst_req | output | 1 | Chip reset request, held until rst_n |
| wake_pulse | output | 1 | One wdt_clk-cycle wake-up pulse |

## Verification
Register reads are combinational and are sampled 1 ns after the address changes. Write readback is checked one system cycle later. Anything that passes into the slow domain has a window of latency: a write or clear takes 3 to 4 wdt_clk edges to be captured. For this reason, timeout checks bracket the expected 2^E slow periods with a lower bound a little below that value, where no reset may yet be seen, and an upper bound a few slow cycles above it, where one must have been seen. The exact 2-cycle delay from a bad captured key to the reset request, and the one-cycle wake width, are checked cycle by cycle against the slow-domain state. The bench reads the sticky flag only after its reset-controller model has pulsed rst_n, which gives the flag synchroniser its 3 system cycles.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int CTRL_W = 8;
    localparam int KEY_HI = 7;
    localparam int KEY_LO = 3;
    localparam int SEL_HI = 2;
    localparam int SEL_LO = 0;
    localparam int KEY_W  = KEY_HI - KEY_LO + 1;
    localparam int SEL_W  = SEL_HI - SEL_LO + 1;
    localparam int EXP_W  = 5;

    localparam logic [KEY_W-1:0]  KEY_RUN_A = 5'b01010;
    localparam logic [KEY_W-1:0]  KEY_RUN_B = 5'b10101;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h53;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Legal arming patterns: both keep the counter running.
    function automatic logic key_ok(input logic [KEY_W-1:0] k);
        return (k == KEY_RUN_A) || (k == KEY_RUN_B);
    endfunction

    // Power-of-two exponent: steps of two for low codes, steps of one above.
    function automatic logic [EXP_W-1:0] sel_exp(input logic [SEL_W-1:0] s);
        logic [EXP_W-1:0] e;
        if (s[SEL_W-1]) e = EXP_W'(11) + EXP_W'(s);
        else            e = EXP_W'(8) + EXP_W'({s, 1'b0});
        return e;
    endfunction
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = d;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: RST_VAL, stab: RST_VAL};
        else        s_q <= s_d;
    end

    assign q = s_q.stab;
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              wdt_clr,
    input  logic              req_sync,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              upd_tgl_o,
    output logic              clr_tgl_o,
    output logic              flag_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              upd_tgl;
        logic              clr_tgl;
    } regs_t;

    regs_t r_d, r_q;
    logic  flag_d, flag_q;
    logic  wr_ctrl, wr_stat;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        r_d     = r_q;
        if (wr_ctrl) begin
            r_d.ctrl    = reg_wdata;
            r_d.upd_tgl = ~r_q.upd_tgl;
        end
        if (wdt_clr) begin
            r_d.clr_tgl = ~r_q.clr_tgl;
        end
        // Set has priority over a software clear in the same cycle.
        if (req_sync)                    flag_d = 1'b1;
        else if (wr_stat && !reg_wdata[0]) flag_d = 1'b0;
        else                             flag_d = flag_q;
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: CTRL_RST, upd_tgl: 1'b0, clr_tgl: 1'b0};
        else        r_q <= r_d;
    end

    // The flag only listens to power-on reset, so it outlives chip resets.
    always_ff @(posedge clk_sys or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    always_comb begin
        if (reg_addr == ADDR_STAT) reg_rdata = {{(CTRL_W-1){1'b0}}, flag_q};
        else                       reg_rdata = r_q.ctrl;
    end

    assign ctrl_o    = r_q.ctrl;
    assign upd_tgl_o = r_q.upd_tgl;
    assign clr_tgl_o = r_q.clr_tgl;
    assign flag_o    = flag_q;
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic              clk_wdt,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_src,
    input  logic              upd_tgl_s,
    input  logic              clr_tgl_s,
    input  logic              pd_s,
    output logic              chip_rst_req,
    output logic              wake_pulse,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int CMP_W = CNT_W + 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              upd_seen;
        logic              clr_seen;
        logic [CNT_W-1:0]  cnt;
        logic              bad_dly;
        logic              req;
        logic              wake;
    } core_t;

    core_t c_d, c_q;
    logic              upd_edge, clr_edge, hit, tmo;
    logic [CMP_W-1:0]  lim;
    logic [EXP_W-1:0]  expo;

    always_comb begin
        c_d          = c_q;
        upd_edge     = upd_tgl_s ^ c_q.upd_seen;
        clr_edge     = clr_tgl_s ^ c_q.clr_seen;
        c_d.upd_seen = upd_tgl_s;
        c_d.clr_seen = clr_tgl_s;
        // The sys-side register has been stable since the toggle flipped.
        if (upd_edge) c_d.ctrl = ctrl_src;

        expo = sel_exp(c_q.ctrl[SEL_HI:SEL_LO]);
        lim  = (CMP_W'(1) << expo) - CMP_W'(1);
        hit  = ({1'b0, c_q.cnt} >= lim);
        tmo  = hit && !clr_edge;

        if (clr_edge || hit) c_d.cnt = '0;
        else                 c_d.cnt = c_q.cnt + CNT_W'(1);

        c_d.bad_dly = !key_ok(c_q.ctrl[KEY_HI:KEY_LO]);
        c_d.req     = c_q.req | c_q.bad_dly | (tmo & ~pd_s);
        c_d.wake    = tmo & pd_s;
    end

    always_ff @(posedge clk_wdt or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{ctrl: CTRL_RST, upd_seen: 1'b0, clr_seen: 1'b0,
                     cnt: '0, bad_dly: 1'b0, req: 1'b0, wake: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign chip_rst_req = c_q.req;
    assign wake_pulse   = c_q.wake;
    assign ctrl_o       = c_q.ctrl;
    assign cnt_o        = c_q.cnt;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic              clk_sys,
    input  logic              clk_wdt,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              wdt_clr,
    input  logic              pwr_down,
    output logic              chip_rst_req,
    output logic              wake_pulse
);
    logic              any_rst_n;
    logic [CTRL_W-1:0] ctrl_sys, ctrl_wdt;
    logic              upd_tgl, clr_tgl, upd_tgl_s, clr_tgl_s, pd_s;
    logic              req_sys, wdt_flag;
    logic [CNT_W-1:0]  cnt_wdt;

    assign any_rst_n = por_n & rst_n;

    kwdt_regs u_regs (
        .clk_sys   (clk_sys),
        .rst_n     (any_rst_n),
        .por_n     (por_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wdt_clr   (wdt_clr),
        .req_sync  (req_sys),
        .ctrl_o    (ctrl_sys),
        .upd_tgl_o (upd_tgl),
        .clr_tgl_o (clr_tgl),
        .flag_o    (wdt_flag)
    );

    kwdt_sync #(.WIDTH(3), .RST_VAL(3'b000)) u_sync_wdt (
        .clk   (clk_wdt),
        .rst_n (any_rst_n),
        .d     ({upd_tgl, clr_tgl, pwr_down}),
        .q     ({upd_tgl_s, clr_tgl_s, pd_s})
    );

    kwdt_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_sync_req (
        .clk   (clk_sys),
        .rst_n (por_n),
        .d     (chip_rst_req),
        .q     (req_sys)
    );

    kwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk_wdt      (clk_wdt),
        .rst_n        (any_rst_n),
        .ctrl_src     (ctrl_sys),
        .upd_tgl_s    (upd_tgl_s),
        .clr_tgl_s    (clr_tgl_s),
        .pd_s         (pd_s),
        .chip_rst_req (chip_rst_req),
        .wake_pulse   (wake_pulse),
        .ctrl_o       (ctrl_wdt),
        .cnt_o        (cnt_wdt)
    );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk_sys,
    input logic             clk_wdt,
    input logic             rst_n,
    input logic             por_n,
    input logic [7:0]       ctrl_w,
    input logic [CNT_W-1:0] cnt_w,
    input logic             req,
    input logic             wake,
    input logic             req_sync,
    input logic             flag
);
    logic             all_n;
    logic             key_bad;
    logic [CNT_W:0]   lim_chk;

    assign all_n   = rst_n & por_n;
    assign key_bad = (ctrl_w[7:3] != 5'b01010) && (ctrl_w[7:3] != 5'b10101);

    always_comb begin
        case (ctrl_w[2:0])
            3'd0:    lim_chk = (CNT_W+1)'(32'd255);
            3'd1:    lim_chk = (CNT_W+1)'(32'd1023);
            3'd2:    lim_chk = (CNT_W+1)'(32'd4095);
            3'd3:    lim_chk = (CNT_W+1)'(32'd16383);
            3'd4:    lim_chk = (CNT_W+1)'(32'd32767);
            3'd5:    lim_chk = (CNT_W+1)'(32'd65535);
            3'd6:    lim_chk = (CNT_W+1)'(32'd131071);
            default: lim_chk = (CNT_W+1)'(32'd262143);
        endcase
    end

    AST_KEY_RST: assert property (@(posedge clk_wdt) disable iff (!all_n)
        key_bad |=> ##1 req); // R3
    AST_REQ_HOLD: assert property (@(posedge clk_wdt) disable iff (!all_n)
        req |=> req); // R9
    AST_WAKE_ONE: assert property (@(posedge clk_wdt) disable iff (!all_n)
        wake |=> !wake); // R8
    AST_CNT_STEP: assert property (@(posedge clk_wdt) disable iff (!all_n)
        (cnt_w != '0) |-> (cnt_w == $past(cnt_w) + CNT_W'(1))); // R4
    AST_CNT_BOUND: assert property (@(posedge clk_wdt) disable iff (!all_n)
        $stable(ctrl_w) |-> ({1'b0, cnt_w} <= lim_chk)); // R5
    AST_FLAG_SET: assert property (@(posedge clk_sys) disable iff (!por_n)
        req_sync |=> flag); // R7
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_sys  (clk_sys),
    .clk_wdt  (clk_wdt),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .ctrl_w   (ctrl_wdt),
    .cnt_w    (cnt_wdt),
    .req      (chip_rst_req),
    .wake     (wake_pulse),
    .req_sync (req_sys),
    .flag     (wdt_flag)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
    logic       clk_sys, clk_wdt;
    logic       por_n, bench_rst_n, ctl_rst_n, rst_n;
    logic       reg_wr, reg_addr, wdt_clr, pwr_down;
    logic [7:0] reg_wdata, reg_rdata;
    logic       chip_rst_req, wake_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int rst_events = 0;
    int wake_cnt = 0;
    int wake_wide = 0;
    logic wake_prev = 1'b0;
    bit done = 1'b0;

    assign rst_n = bench_rst_n & ctl_rst_n;

    kwdt_top uut (
        .clk_sys(clk_sys), .clk_wdt(clk_wdt), .por_n(por_n), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wdt_clr(wdt_clr), .pwr_down(pwr_down),
        .chip_rst_req(chip_rst_req), .wake_pulse(wake_pulse)
    );

    initial begin clk_sys = 1'b0; forever #10 clk_sys = ~clk_sys; end
    initial begin clk_wdt = 1'b0; #7; forever #50 clk_wdt = ~clk_wdt; end

    // Reset-controller model: answers a request with a chip reset pulse.
    initial ctl_rst_n = 1'b1;
    always @(posedge clk_sys) begin
        if (chip_rst_req === 1'b1 && ctl_rst_n) begin
            rst_events <= rst_events + 1;
            repeat (6) @(posedge clk_sys);
            ctl_rst_n <= 1'b0;
            repeat (4) @(posedge clk_sys);
            ctl_rst_n <= 1'b1;
        end
    end

    always @(negedge clk_wdt) begin
        if (wake_pulse === 1'b1) begin
            if (!wake_prev) wake_cnt <= wake_cnt + 1;
            else            wake_wide <= wake_wide + 1;
        end
        wake_prev <= (wake_pulse === 1'b1);
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sys_cycles(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic slow_cycles(input int n);
        sys_cycles(n * 5);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk_sys);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1'b1;
        @(negedge clk_sys);
        wdt_clr = 1'b0;
    endtask

    task automatic settle();
        sys_cycles(30);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R2 ctrl after power-on", v, 8'h53);
        rd(1'b1, v); check("R7 flag after power-on", v, 8'h00);
        check("R9 no request after reset", chip_rst_req, 0);
        check("R8 no wake after reset", wake_pulse, 0);
    endtask

    task automatic t_readwrite();
        logic [7:0] v;
        wr(1'b0, 8'hA9);
        rd(1'b0, v); check("R1 ctrl readback", v, 8'hA9);
        wr(1'b0, 8'h53);
        rd(1'b0, v); check("R1 ctrl readback restore", v, 8'h53);
    endtask

    task automatic t_clear_timeout();
        int ev;
        logic [7:0] v;
        ev = rst_events;
        wr(1'b0, 8'h50);
        pulse_clr();
        for (int i = 0; i < 4; i++) begin
            slow_cycles(200);
            pulse_clr();
        end
        check("R6 clears hold off timeout", rst_events - ev, 0);
        slow_cycles(240);
        check("R4 no timeout before 2^8", rst_events - ev, 0);
        slow_cycles(40);
        check("R4 timeout at 2^8", rst_events - ev, 1);
        settle();
        rd(1'b1, v); check("R7 flag set by timeout", v, 8'h01);
        rd(1'b0, v); check("R2 ctrl reloaded by chip reset", v, 8'h53);
    endtask

    task automatic t_sel1();
        int ev;
        ev = rst_events;
        wr(1'b0, 8'h51);
        pulse_clr();
        slow_cycles(1000);
        check("R4 no timeout before 2^10", rst_events - ev, 0);
        slow_cycles(40);
        check("R4 timeout at 2^10", rst_events - ev, 1);
        settle();
    endtask

    task automatic t_shrink();
        int ev;
        ev = rst_events;
        wr(1'b0, 8'h51);
        pulse_clr();
        slow_cycles(600);
        check("R5 no timeout at count 600 with 2^10", rst_events - ev, 0);
        wr(1'b0, 8'h50);
        sys_cycles(60);
        check("R5 lowered select fires at once", rst_events - ev, 1);
        settle();
    endtask

    task automatic t_key_alt();
        int ev;
        logic [7:0] v;
        ev = rst_events;
        wr(1'b0, 8'h50);
        pulse_clr();
        for (int i = 0; i < 6; i++) begin
            slow_cycles(100);
            wr(1'b0, (i % 2 == 0) ? 8'hA8 : 8'h50);
            pulse_clr();
        end
        check("R3 both keys keep running", rst_events - ev, 0);
        rd(1'b0, v); check("R10 ctrl holds last write", v, 8'h50);
        wr(1'b0, 8'h53);
        pulse_clr();
    endtask

    task automatic t_flag_sw();
        logic [7:0] v;
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R7 writing 1 keeps flag", v, 8'h01);
        wr(1'b1, 8'hFE);
        rd(1'b1, v); check("R7 writing 0 clears flag", v, 8'h00);
        wr(1'b1, 8'h01);
        rd(1'b1, v); check("R7 writing 1 does not set", v, 8'h00);
    endtask

    task automatic t_key_bad();
        int ev;
        logic [7:0] v;
        ev = rst_events;
        wr(1'b0, 8'h03);
        sys_cycles(2);
        check("R3 request not immediate", rst_events - ev, 0);
        sys_cycles(40);
        check("R3 bad key requests reset", rst_events - ev, 1);
        settle();
        rd(1'b1, v); check("R7 flag set by bad key", v, 8'h01);
        rd(1'b0, v); check("R2 ctrl reloaded after key reset", v, 8'h53);
    endtask

    task automatic t_pwr_down();
        int ev, wk, ww;
        logic [7:0] v;
        ev = rst_events; wk = wake_cnt; ww = wake_wide;
        wr(1'b0, 8'hA8);
        pulse_clr();
        pwr_down = 1'b1;
        slow_cycles(600);
        check("R8 two wake pulses", wake_cnt - wk, 2);
        check("R8 wake pulse one slow cycle", wake_wide - ww, 0);
        check("R8 no reset in power-down", rst_events - ev, 0);
        rd(1'b0, v); check("R8 ctrl unchanged in power-down", v, 8'hA8);
        rd(1'b1, v); check("R8 flag untouched in power-down", v, 8'h00);
        pwr_down = 1'b0;
        pulse_clr();
        wr(1'b0, 8'h53);
        pulse_clr();
    endtask

    initial begin
        por_n = 1'b0; bench_rst_n = 1'b0;
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
        wdt_clr = 1'b0; pwr_down = 1'b0;
        sys_cycles(5);
        por_n = 1'b1; bench_rst_n = 1'b1;
        sys_cycles(3);
        t_reset();
        t_readwrite();
        t_clear_timeout();
        t_sel1();
        t_shrink();
        t_key_alt();
        t_flag_sw();
        t_key_bad();
        t_flag_sw();
        t_pwr_down();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk_sys);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule